// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Masked Alarm

This block keeps a packed-BCD time of day (seconds, minutes, hours in 24-hour form, day of month, month, two-digit year) and a weekday count. All fields advance on a one-cycle `tick_i` pulse that a companion divider delivers once per second. A mode input, `cal_en_i`, sets the role of the date fields. When it is 1, day, month and year follow the calendar, with month lengths and leap years. When it is 0, those three fields stop counting and become plain byte storage, which a `protect_i` input from a companion controller can lock against writes.

A second bank of seven alarm registers, in the same field order, is compared against the value the counters take at each tick. A 7-bit enable mask chooses which fields take part. The alarm flag latches when every enabled field matches, and it stays set until an explicit clear. The register write and read ports are plain control ports with no handshake: a write is taken in the cycle `wr_en_i` is high, and the read data follows `rd_addr_i` without a clock. Nothing in the block can stall, so no back-pressure applies.

Address map: bit 3 of an address selects the bank (0 = counters, 1 = alarms). Bits 2:0 select the field: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday. Field code 7 is unused.

Top module: `rtc_cal_counter`

## Requirements
- R1: After reset every counter reads 0x00, except day and month, which read 0x01. Every alarm register reads 0x00 and `alarm_flag_o` is 0.
- R2: On each tick, seconds advance in BCD and wrap from 0x59 to 0x00 with a carry into minutes. Minutes wrap the same way with a carry into hours. Hours wrap from 0x23 to 0x00, which is a day rollover.
- R3: With `cal_en_i`=1, a day rollover advances the day up to the month's last day and then returns it to 0x01 with a carry into the month. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11; 0x29 for 0x02 when the year value is divisible by four, otherwise 0x28; and 0x31 for every other month. Month wraps from 0x12 to 0x01 with a carry into the year, and year wraps from 0x99 to 0x00.
- R4: With `cal_en_i`=0, ticks never change day, month or year. Seconds, minutes, hours and weekday keep counting.
- R5: Weekday advances by one on every day rollover, in either mode, and wraps from 6 to 0.
- R6: With `cal_en_i`=0 and `protect_i`=0, a write to day, month or year stores all 8 bits as given and reads back unchanged.
- R7: With `cal_en_i`=1, a write to day stores bits 7:6 as 0, and a write to month stores bits 7:5 as 0, whatever was written.
- R8: With `cal_en_i`=0 and `protect_i`=1, writes to day, month and year are ignored. Writes to the other counters and to the alarm bank are never blocked by `protect_i`.
- R9: `alarm_flag_o` goes to 1 at the clock edge of a tick whose new counter values equal the alarm registers in every field whose mask bit is 1. Mask bit i belongs to field code i. A mismatch in an enabled field leaves the flag unchanged.
- R10: With `cal_en_i`=0, the day, month and year fields always count as matching, whatever their mask bits and values.
- R11: Once set, the flag holds through later ticks and reads. It goes to 0 at the edge after `alarm_clr_i`=1. If a set and a clear happen in the same cycle, the set wins.
- R12: A counter write in the same cycle as a tick stores the written value in that field, while the other fields still tick. Reading field code 7 in either bank returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| cal_en_i | input | 1 | 1 = date fields count, 0 = date fields are storage |
| protect_i | input | 1 | Write lock for date storage when `cal_en_i`=0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address: bank bit 3, field code bits 2:0 |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address, same layout |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| alarm_mask_i | input | 7 | Per-field alarm enable, bit i = field code i |
| alarm_clr_i | input | 1 | Clears the alarm flag |
| alarm_flag_o | output | 1 | Latched alarm flag |

## Verification
A write or a tick updates the registers at the next rising edge. The read port is combinational, so a new value shows on `rd_data_o` one edge after the stimulus. The alarm flag is registered from the same edge that updates the counters, so it also appears one edge after the tick. Set and clear therefore share a single cycle of latency.

The bench drives every stimulus on a falling edge and holds it for one full cycle. It samples both the read data and the flag on the following falling edge, half a cycle after the edge that made the change. Corner dates are loaded with writes at 23:59:59, so each rollover case needs only one tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WDAY = 6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] field_rst(input int f);
    return (f == F_DAY || f == F_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  logic [7:0] month_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_day_o
);
  logic [6:0] year_bin;
  logic       leap;

  assign year_bin = bcd_to_bin(year_i);
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    case (month_i)
      8'h02:                     last_day_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                   last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] cand_i,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_i,
  input  logic [NUM_FIELDS-1:0]             mask_i,
  input  logic                              cal_en_i,
  output logic                              hit_o
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    if (f == F_DAY || f == F_MON || f == F_YEAR) begin : g_date
      assign fld_ok[f] = !cal_en_i || !mask_i[f] || (cand_i[f] == alarm_i[f]);
    end else begin : g_time
      assign fld_ok[f] = !mask_i[f] || (cand_i[f] == alarm_i[f]);
    end
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick_i,
  input  logic                              cal_en_i,
  input  logic                              protect_i,
  input  logic                              wr_en_i,
  input  logic [FIELD_W-1:0]                wr_field_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] cnt_q_o,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] cnt_d_o
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] tick_nxt;
  logic [DATA_W-1:0] last_day;
  logic c_sec, c_min, c_hour, c_day, c_mon;
  logic is_date, wr_ok;
  logic [DATA_W-1:0] wmask;

  rtc_month_len u_mlen (
    .month_i    (cnt_q_o[F_MON]),
    .year_i     (cnt_q_o[F_YEAR]),
    .last_day_o (last_day)
  );

  // carry chain, all from current values
  assign c_sec  = tick_i && (cnt_q_o[F_SEC]  >= 8'h59);
  assign c_min  = c_sec  && (cnt_q_o[F_MIN]  >= 8'h59);
  assign c_hour = c_min  && (cnt_q_o[F_HOUR] >= 8'h23);
  assign c_day  = c_hour && cal_en_i && (cnt_q_o[F_DAY] >= last_day);
  assign c_mon  = c_day  && (cnt_q_o[F_MON]  >= 8'h12);

  always_comb begin
    tick_nxt = cnt_q_o;
    if (tick_i)
      tick_nxt[F_SEC]  = (cnt_q_o[F_SEC]  >= 8'h59) ? 8'h00 : bcd_inc(cnt_q_o[F_SEC]);
    if (c_sec)
      tick_nxt[F_MIN]  = (cnt_q_o[F_MIN]  >= 8'h59) ? 8'h00 : bcd_inc(cnt_q_o[F_MIN]);
    if (c_min)
      tick_nxt[F_HOUR] = (cnt_q_o[F_HOUR] >= 8'h23) ? 8'h00 : bcd_inc(cnt_q_o[F_HOUR]);
    if (c_hour)
      tick_nxt[F_WDAY] = (cnt_q_o[F_WDAY] >= 8'h06) ? 8'h00 : cnt_q_o[F_WDAY] + 8'h01;
    if (c_hour && cal_en_i)
      tick_nxt[F_DAY]  = (cnt_q_o[F_DAY]  >= last_day) ? 8'h01 : bcd_inc(cnt_q_o[F_DAY]);
    if (c_day)
      tick_nxt[F_MON]  = (cnt_q_o[F_MON]  >= 8'h12) ? 8'h01 : bcd_inc(cnt_q_o[F_MON]);
    if (c_mon)
      tick_nxt[F_YEAR] = (cnt_q_o[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cnt_q_o[F_YEAR]);
  end

  // write qualification and reserved-bit masking
  always_comb begin
    is_date = (wr_field_i == FIELD_W'(F_DAY)) || (wr_field_i == FIELD_W'(F_MON)) ||
              (wr_field_i == FIELD_W'(F_YEAR));
    wmask = '1;
    if (cal_en_i && wr_field_i == FIELD_W'(F_DAY)) wmask = 8'h3F;
    if (cal_en_i && wr_field_i == FIELD_W'(F_MON)) wmask = 8'h1F;
    wr_ok = wr_en_i && (wr_field_i < FIELD_W'(NUM_FIELDS)) &&
            !(is_date && !cal_en_i && protect_i);
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cnt
    assign cnt_d_o[f] = (wr_ok && wr_field_i == FIELD_W'(f)) ? (wr_data_i & wmask)
                                                           : tick_nxt[f];
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q_o[f] <= field_rst(f);
      else        cnt_q_o[f] <= cnt_d_o[f];
    end
  end
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cal_en_i,
  input  logic              protect_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [6:0]        alarm_mask_i,
  input  logic              alarm_clr_i,
  output logic              alarm_flag_o
);
  localparam int FIELD_W = ADDR_W - 1;

  logic [NUM_FIELDS-1:0][DATA_W-1:0] cnt_q, cnt_d, alm_q;
  logic [FIELD_W-1:0] wr_field, rd_field;
  logic wr_bank, rd_bank, alarm_hit;

  assign wr_field = wr_addr_i[FIELD_W-1:0];
  assign wr_bank  = wr_addr_i[ADDR_W-1];
  assign rd_field = rd_addr_i[FIELD_W-1:0];
  assign rd_bank  = rd_addr_i[ADDR_W-1];

  rtc_time_core #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .cal_en_i   (cal_en_i),
    .protect_i  (protect_i),
    .wr_en_i    (wr_en_i && !wr_bank),
    .wr_field_i (wr_field),
    .wr_data_i  (wr_data_i),
    .cnt_q_o    (cnt_q),
    .cnt_d_o    (cnt_d)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rst_n) alm_q[f] <= '0;
      else if (wr_en_i && wr_bank && wr_field == FIELD_W'(f)) alm_q[f] <= wr_data_i;
    end
  end

  rtc_alarm_cmp #(.DATA_W(DATA_W)) u_cmp (
    .cand_i   (cnt_d),
    .alarm_i  (alm_q),
    .mask_i   (alarm_mask_i),
    .cal_en_i (cal_en_i),
    .hit_o    (alarm_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  alarm_flag_o <= 1'b0;
    else if (tick_i && alarm_hit) alarm_flag_o <= 1'b1;
    else if (alarm_clr_i)        alarm_flag_o <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_field < FIELD_W'(NUM_FIELDS))
      rd_data_o = rd_bank ? alm_q[rd_field] : cnt_q[rd_field];
  end
endmodule

// File: rtl/rtc_cal_counter_chk.sv
module rtc_cal_counter_chk
  import rtc_cal_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick_i,
  input logic                        cal_en_i,
  input logic                        protect_i,
  input logic                        wr_en_i,
  input logic [3:0]                  wr_addr_i,
  input logic                        alarm_clr_i,
  input logic                        alarm_flag_o,
  input logic                        hit_i,
  input logic [NUM_FIELDS-1:0][7:0]  cnt_i
);
  p_seconds_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_en_i && cnt_i[F_SEC] == 8'h59 |=> cnt_i[F_SEC] == 8'h00);

  p_date_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en_i && !wr_en_i |=> $stable(cnt_i[F_DAY]) && $stable(cnt_i[F_MON]) &&
                              $stable(cnt_i[F_YEAR]));

  p_rsv_day_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_en_i && wr_en_i && wr_addr_i == 4'd3 |=> cnt_i[F_DAY][7:6] == 2'b00);

  p_rsv_mon_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_en_i && wr_en_i && wr_addr_i == 4'd4 |=> cnt_i[F_MON][7:5] == 3'b000);

  p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en_i && protect_i && wr_en_i && (wr_addr_i == 4'd3 || wr_addr_i == 4'd4 ||
    wr_addr_i == 4'd5) |=> $stable(cnt_i[F_DAY]) && $stable(cnt_i[F_MON]) &&
                           $stable(cnt_i[F_YEAR]));

  p_alarm_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && hit_i |=> alarm_flag_o);

  p_alarm_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag_o) |-> $past(tick_i));

  p_alarm_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clr_i && !(tick_i && hit_i) |=> !alarm_flag_o);
endmodule

bind rtc_cal_counter rtc_cal_counter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .cal_en_i     (cal_en_i),
  .protect_i    (protect_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .alarm_clr_i  (alarm_clr_i),
  .alarm_flag_o (alarm_flag_o),
  .hit_i        (alarm_hit),
  .cnt_i        (cnt_q)
);

// File: tb/rtc_cal_counter_tb.sv
module rtc_cal_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       cal_en_i = 1'b1;
  logic       protect_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [6:0] alarm_mask_i = '0;
  logic       alarm_clr_i = 1'b0;
  logic       alarm_flag_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_cal_counter dut_i (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .cal_en_i (cal_en_i),
    .protect_i (protect_i), .wr_en_i (wr_en_i), .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i), .rd_addr_i (rd_addr_i), .rd_data_o (rd_data_o),
    .alarm_mask_i (alarm_mask_i), .alarm_clr_i (alarm_clr_i),
    .alarm_flag_o (alarm_flag_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    rd_addr_i = a;
    #1;
    check(req, rd_data_o, exp);
  endtask

  task automatic tick1();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk); alarm_clr_i = 1'b1;
    @(negedge clk); alarm_clr_i = 1'b0;
  endtask

  task automatic set_clock(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                           input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                           input logic [7:0] w);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
    wr(4'd3, d); wr(4'd4, mo); wr(4'd5, y); wr(4'd6, w);
  endtask

  task automatic t_reset();
    rd_chk("R1 sec", 4'd0, 8'h00);
    rd_chk("R1 day", 4'd3, 8'h01);
    rd_chk("R1 month", 4'd4, 8'h01);
    rd_chk("R1 weekday", 4'd6, 8'h00);
    rd_chk("R1 alarm sec", 4'd8, 8'h00);
    check("R1 flag", {7'd0, alarm_flag_o}, 8'h00);
  endtask

  task automatic t_time_roll();
    cal_en_i = 1'b1;
    set_clock(8'h23, 8'h59, 8'h58, 8'h28, 8'h02, 8'h23, 8'h06);
    tick1();
    rd_chk("R2 sec step", 4'd0, 8'h59);
    rd_chk("R2 min held", 4'd1, 8'h59);
    tick1();
    rd_chk("R2 sec wrap", 4'd0, 8'h00);
    rd_chk("R2 min wrap", 4'd1, 8'h00);
    rd_chk("R2 hour wrap", 4'd2, 8'h00);
    rd_chk("R3 feb28 nonleap day", 4'd3, 8'h01);
    rd_chk("R3 feb28 nonleap month", 4'd4, 8'h03);
    rd_chk("R5 weekday wrap", 4'd6, 8'h00);
  endtask

  task automatic t_calendar();
    cal_en_i = 1'b1;
    set_clock(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24, 8'h01);
    tick1();
    rd_chk("R3 leap feb29", 4'd3, 8'h29);
    rd_chk("R5 weekday step", 4'd6, 8'h02);
    set_clock(8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h24, 8'h01);
    tick1();
    rd_chk("R3 leap mar1 day", 4'd3, 8'h01);
    rd_chk("R3 leap mar1 month", 4'd4, 8'h03);
    set_clock(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h24, 8'h01);
    tick1();
    rd_chk("R3 apr30 day", 4'd3, 8'h01);
    rd_chk("R3 apr30 month", 4'd4, 8'h05);
    set_clock(8'h23, 8'h59, 8'h59, 8'h30, 8'h05, 8'h24, 8'h01);
    tick1();
    rd_chk("R3 may31 exists", 4'd3, 8'h31);
    set_clock(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 8'h01);
    tick1();
    rd_chk("R3 year end day", 4'd3, 8'h01);
    rd_chk("R3 year end month", 4'd4, 8'h01);
    rd_chk("R3 year wrap", 4'd5, 8'h00);
  endtask

  task automatic t_storage_hold();
    cal_en_i = 1'b0; protect_i = 1'b0;
    set_clock(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 8'h03);
    tick1();
    rd_chk("R4 hour still wraps", 4'd2, 8'h00);
    rd_chk("R4 day held", 4'd3, 8'h31);
    rd_chk("R4 month held", 4'd4, 8'h12);
    rd_chk("R4 year held", 4'd5, 8'h99);
    rd_chk("R5 weekday in storage mode", 4'd6, 8'h04);
  endtask

  task automatic t_storage_rw();
    cal_en_i = 1'b0; protect_i = 1'b0;
    wr(4'd3, 8'hFF); wr(4'd4, 8'hE7); wr(4'd5, 8'hAB);
    rd_chk("R6 day raw", 4'd3, 8'hFF);
    rd_chk("R6 month raw", 4'd4, 8'hE7);
    rd_chk("R6 year raw", 4'd5, 8'hAB);
    protect_i = 1'b1;
    wr(4'd3, 8'h11); wr(4'd5, 8'h22);
    rd_chk("R8 day locked", 4'd3, 8'hFF);
    rd_chk("R8 year locked", 4'd5, 8'hAB);
    wr(4'd0, 8'h12); wr(4'd9, 8'h34);
    rd_chk("R8 sec not locked", 4'd0, 8'h12);
    rd_chk("R8 alarm not locked", 4'd9, 8'h34);
    protect_i = 1'b0;
  endtask

  task automatic t_reserved();
    cal_en_i = 1'b1;
    wr(4'd3, 8'hDD);
    rd_chk("R7 day reserved", 4'd3, 8'h1D);
    wr(4'd4, 8'hF2);
    rd_chk("R7 month reserved", 4'd4, 8'h12);
  endtask

  task automatic t_alarm();
    cal_en_i = 1'b1;
    set_clock(8'h10, 8'h20, 8'h30, 8'h05, 8'h06, 8'h07, 8'h02);
    wr(4'd8, 8'h31); wr(4'd9, 8'h20); wr(4'd11, 8'h09);
    alarm_mask_i = 7'b0000011;
    clr_flag();
    check("R11 clear", {7'd0, alarm_flag_o}, 8'h00);
    tick1();
    check("R9 set on match", {7'd0, alarm_flag_o}, 8'h01);
    rd_chk("R11 read does not clear", 4'd8, 8'h31);
    check("R11 held after read", {7'd0, alarm_flag_o}, 8'h01);
    tick1();
    check("R11 held after tick", {7'd0, alarm_flag_o}, 8'h01);
    clr_flag();
    check("R11 cleared", {7'd0, alarm_flag_o}, 8'h00);
    alarm_mask_i = 7'b0001011;
    wr(4'd0, 8'h30);
    tick1();
    check("R9 day mismatch blocks", {7'd0, alarm_flag_o}, 8'h00);
    alarm_mask_i = 7'b0000011;
    wr(4'd0, 8'h30);
    @(negedge clk); tick_i = 1'b1; alarm_clr_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; alarm_clr_i = 1'b0;
    check("R11 set beats clear", {7'd0, alarm_flag_o}, 8'h01);
  endtask

  task automatic t_alarm_storage();
    cal_en_i = 1'b0;
    clr_flag();
    wr(4'd8, 8'h41);
    wr(4'd0, 8'h40);
    alarm_mask_i = 7'b0111001;
    tick1();
    check("R10 date fields forced match", {7'd0, alarm_flag_o}, 8'h01);
    clr_flag();
    wr(4'd0, 8'h39);
    tick1();
    check("R10 sec still compared", {7'd0, alarm_flag_o}, 8'h00);
  endtask

  task automatic t_write_vs_tick();
    cal_en_i = 1'b1;
    set_clock(8'h05, 8'h59, 8'h59, 8'h10, 8'h03, 8'h20, 8'h01);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = 8'h45;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd_chk("R12 write wins", 4'd0, 8'h45);
    rd_chk("R12 other field ticks", 4'd1, 8'h00);
    rd_chk("R12 hour carry", 4'd2, 8'h06);
    rd_chk("R12 unused code cnt", 4'd7, 8'h00);
    rd_chk("R12 unused code alarm", 4'd15, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_time_roll();
    t_calendar();
    t_storage_hold();
    t_storage_rw();
    t_reserved();
    t_alarm();
    t_alarm_storage();
    t_write_vs_tick();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule